// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Register

This block supervises software with a free-running interval counter. Software arms it by writing a control byte with the control bit at position 2 cleared. That same byte chooses one of four interval lengths, which stay fixed until the counter stops. Each later write with bit 2 cleared restarts the count. If software does not restart the count before the chosen number of ticks has passed, the block raises a one-cycle reset request. It then falls back to the idle, unarmed state. The ticks come from one of two clock-enable sources: a slow sub-timer tick or a tick derived from the main clock. A select input chooses between them.

The same byte address also reports why the chip last came out of reset. The causes are power-up, watchdog expiry, the external reset pin and a software-issued reset. These flags live in a domain that only the power-up reset clears, so they survive the system reset that the watchdog itself triggers. A read returns the flags and then clears them. When the power-up flag is set, software treats the other flags as meaningless.

The register interface is a plain synchronous strobe bus: one write strobe, one read strobe, and 8-bit write and read data. Every access completes in one cycle and there is no back-pressure. Read data is registered and valid in the cycle after the read strobe.

Top module: `wdog_ctrl`

## Requirements
- R1: While `por_n` is low, the power-up cause flag is set and every other cause flag is cleared. A read after power-up returns 0x08, and `wdt_rst_o` stays low.
- R2: Before the first start, no number of ticks produces a reset request, and the counter is held at zero.
- R3: A write with bit 2 equal to 0 while the watchdog is idle starts it and latches interval code `wdata_i[1:0]`. Code n gives an interval of 2^(BASE_LOG2 + n*STEP_LOG2) ticks, so the defaults give 2^12, 2^14, 2^16 and 2^18 ticks.
- R4: While the watchdog is running, a write with bit 2 equal to 0 restarts the count from zero. A write with bit 2 equal to 1 changes nothing.
- R5: Interval bits written while the watchdog is running are ignored. The interval latched at start stays in force.
- R6: With `clk_sel_i` = 1 only `main_tick_i` advances the count. With `clk_sel_i` = 0 only `sub_tick_i` advances it.
- R7: On the tick that completes the interval, `wdt_rst_o` goes high in the next cycle for exactly one cycle. The watchdog then returns to the idle state and stays there until it is started again.
- R8: The cause flags read at bit 3 (power-up), bit 4 (watchdog), bit 5 (external pin, set by a pulse on `ext_cause_i`) and bit 7 (software, set by a pulse on `sw_cause_i`). The watchdog flag is set by its own expiry. The flags survive a low `rst_n`.
- R9: `rdata_o` is loaded from the register in the cycle after `rd_en_i`. Bits 0, 1, 2 and 6 read as 0. All cause flags clear after the read.
- R10: A cause event in the same cycle as a read leaves its flag set, and that read returns the old value. A restart write in the same cycle as the final tick wins, so no request is raised.
- R11: Writes never change the cause flags. Bit 6 has no effect on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low; clears the cause domain |
| rst_n | input | 1 | System reset, active low; clears the counter and the bus logic |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_en_i` |
| sub_tick_i | input | 1 | Sub-timer tick enable |
| main_tick_i | input | 1 | Main-clock-derived tick enable |
| clk_sel_i | input | 1 | Tick source: 0 selects sub-timer, 1 selects main |
| ext_cause_i | input | 1 | Pulse: external pin reset occurred |
| sw_cause_i | input | 1 | Pulse: software reset occurred |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Two pairs of functions can land on the same clock edge.

- **Read-clear against a new cause event.** The bench drives `rd_en_i` and `ext_cause_i` together. It expects the returned byte to lack the new flag, and the next read to show it.
- **Restart write against the final tick.** The bench holds the main tick high and places a restart write exactly on the tick that would complete the interval. It expects no request on that edge and a full fresh interval afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_CAUSE = 4;
  localparam int NUM_IVAL  = 4;
  localparam int IVAL_W    = $clog2(NUM_IVAL);

  // bit positions in the control/status byte
  localparam int POS_CTL = 2;
  localparam int POS_POR = 3;
  localparam int POS_WDG = 4;
  localparam int POS_EXT = 5;
  localparam int POS_SW  = 7;

  // index of each cause inside the flag vector
  typedef enum logic [1:0] {
    CAUSE_POR = 2'd0,
    CAUSE_WDG = 2'd1,
    CAUSE_EXT = 2'd2,
    CAUSE_SW  = 2'd3
  } cause_e;

  function automatic int cause_pos(input int idx);
    case (idx)
      0:       return POS_POR;
      1:       return POS_WDG;
      2:       return POS_EXT;
      default: return POS_SW;
    endcase
  endfunction

  typedef struct packed {
    logic              start;
    logic              kick;
    logic [IVAL_W-1:0] ival;
  } ctl_cmd_t;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter bit TICK_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic main_tick,
  input  logic sel_main,
  output logic tick
);
  logic tick_mux;

  assign tick_mux = sel_main ? main_tick : sub_tick;

  generate
    if (TICK_REG) begin : g_reg
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_mux;
      end
      assign tick = tick_q;
    end else begin : g_comb
      assign tick = tick_mux;
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctl_cmd_t             cmd,
  input  logic                 tick,
  output logic                 running,
  output logic                 expire,
  output logic [IVAL_W-1:0]    ival_q,
  output logic [BASE_LOG2+(NUM_IVAL-1)*STEP_LOG2-1:0] count
);
  localparam int CNT_W = BASE_LOG2 + (NUM_IVAL-1)*STEP_LOG2;

  logic [CNT_W-1:0] lim_last [NUM_IVAL];
  logic             at_last;

  for (genvar g = 0; g < NUM_IVAL; g++) begin : g_lim
    localparam int SH = BASE_LOG2 + g*STEP_LOG2;
    assign lim_last[g] = CNT_W'((64'd1 << SH) - 64'd1);
  end

  assign at_last = (count == lim_last[ival_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      expire  <= 1'b0;
      ival_q  <= '0;
      count   <= '0;
    end else begin
      expire <= 1'b0;
      if (cmd.start) begin
        running <= 1'b1;
        ival_q  <= cmd.ival;
        count   <= '0;
      end else if (running) begin
        if (cmd.kick) begin
          count <= '0;
        end else if (tick) begin
          if (at_last) begin
            expire  <= 1'b1;
            running <= 1'b0;
            count   <= '0;
          end else begin
            count <= count + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdog_cause_reg.sv
module wdog_cause_reg
  import wdog_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic [NUM_CAUSE-1:0] set_vec,
  input  logic                 rd_clr,
  output logic [NUM_CAUSE-1:0] flags
);
  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_flag
    localparam bit RST_VAL = (g == int'(CAUSE_POR));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          flags[g] <= RST_VAL;
      else if (set_vec[g]) flags[g] <= 1'b1;
      else if (rd_clr)     flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [POS_CTL:0]     wdata_lo,
  input  logic                 running,
  input  logic [NUM_CAUSE-1:0] flags,
  output ctl_cmd_t             cmd,
  output logic [REG_W-1:0]     rdata
);
  logic             ctl_zero;
  logic [REG_W-1:0] rd_word;

  assign ctl_zero  = wr_en && !wdata_lo[POS_CTL];
  assign cmd.start = ctl_zero && !running;
  assign cmd.kick  = ctl_zero && running;
  assign cmd.ival  = wdata_lo[IVAL_W-1:0];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CAUSE; i++) rd_word[cause_pos(i)] = flags[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter bit TICK_REG  = 1'b0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             sub_tick_i,
  input  logic             main_tick_i,
  input  logic             clk_sel_i,
  input  logic             ext_cause_i,
  input  logic             sw_cause_i,
  output logic             wdt_rst_o
);
  localparam int CNT_W = BASE_LOG2 + (NUM_IVAL-1)*STEP_LOG2;

  ctl_cmd_t             cmd;
  logic                 tick;
  logic                 running;
  logic                 expire;
  logic [IVAL_W-1:0]    ival_q;
  logic [CNT_W-1:0]     count;
  logic [NUM_CAUSE-1:0] set_vec;
  logic [NUM_CAUSE-1:0] flags;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:POS_CTL+1];

  wdog_tick_sel #(.TICK_REG(TICK_REG)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_tick  (sub_tick_i),
    .main_tick (main_tick_i),
    .sel_main  (clk_sel_i),
    .tick      (tick)
  );

  wdog_regif u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .rd_en    (rd_en_i),
    .wdata_lo (wdata_i[POS_CTL:0]),
    .running  (running),
    .flags    (flags),
    .cmd      (cmd),
    .rdata    (rdata_o)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .tick    (tick),
    .running (running),
    .expire  (expire),
    .ival_q  (ival_q),
    .count   (count)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[CAUSE_WDG] = expire;
    set_vec[CAUSE_EXT] = ext_cause_i;
    set_vec[CAUSE_SW]  = sw_cause_i;
  end

  wdog_cause_reg u_cause (
    .clk     (clk),
    .por_n   (por_n),
    .set_vec (set_vec),
    .rd_clr  (rd_en_i),
    .flags   (flags)
  );

  assign wdt_rst_o = expire;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic             ext_cause,
  input logic             sw_cause,
  input logic             running,
  input logic [1:0]       ival,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       flags,
  input logic             wdt_rst
);
  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R2
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !wdt_rst);

  // R5
  ival_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(ival));

  // R4
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && !wdata[2]) |=> (count == '0));

  // R8
  wdg_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |=> flags[1]);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && !ext_cause && !sw_cause && !wdt_rst) |=> (flags == 4'b0000));
endmodule

bind wdog_ctrl wdog_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .wr_en     (wr_en_i),
  .rd_en     (rd_en_i),
  .wdata     (wdata_i),
  .ext_cause (ext_cause_i),
  .sw_cause  (sw_cause_i),
  .running   (running),
  .ival      (ival_q),
  .count     (count),
  .flags     (flags),
  .wdt_rst   (wdt_rst_o)
);

// File: tb/wdog_ctrl_tb.sv
`timescale 1ns/1ps
module wdog_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sub_tick = 1'b0, main_tick = 1'b1, clk_sel = 1'b1;
  logic       ext_c = 1'b0, sw_c = 1'b0;
  logic       wdt_rst;

  int nchk = 0, nfail = 0, pulse_cnt = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] e_item;
  string      r_item;

  always #2.5 clk = ~clk;

  wdog_ctrl #(.BASE_LOG2(3), .STEP_LOG2(1)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .sub_tick_i(sub_tick), .main_tick_i(main_tick),
    .clk_sel_i(clk_sel), .ext_cause_i(ext_c), .sw_cause_i(sw_c), .wdt_rst_o(wdt_rst)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) if (wdt_rst) pulse_cnt++;

  // monitor: pops expected read data as each result appears
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected read", rdata, 0);
      else begin
        e_item = exp_q.pop_front();
        r_item = req_q.pop_front();
        chk(rdata == e_item, r_item, "rdata", rdata, e_item);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic bus_write(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] exp, input string req, input bit with_ext = 1'b0);
    exp_q.push_back(exp); req_q.push_back(req);
    rd_en = 1'b1; ext_c = with_ext;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; ext_c = 1'b0;
  endtask

  task automatic pulse_cause(input bit e, input bit s);
    ext_c = e; sw_c = s;
    @(posedge clk); @(negedge clk);
    ext_c = 1'b0; sw_c = 1'b0;
  endtask

  task automatic wait_expiry(input int exp, input string req);
    int n = 0;
    while (n < exp + 20) begin
      @(posedge clk); n++; @(negedge clk);
      if (wdt_rst) break;
    end
    chk(n == exp, req, "ticks to expiry", n, exp);
    @(posedge clk); @(negedge clk);
    chk(wdt_rst == 1'b0, "R7", "request width", wdt_rst, 0);
  endtask

  task automatic no_pulse_for(input int n, input string req);
    int p0 = pulse_cnt;
    idle(n);
    chk(pulse_cnt == p0, req, "unexpected request", pulse_cnt - p0, 0);
  endtask

  initial begin
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    chk(wdt_rst == 1'b0, "R1", "request after power-up", wdt_rst, 0);
    bus_read(8'h08, "R1");
    bus_read(8'h00, "R9");
    no_pulse_for(50, "R2");
    bus_write(8'hFF);                         // bit2=1: no start, bit6 no effect
    no_pulse_for(40, "R4");
    bus_read(8'h00, "R11");
    // interval codes 0..3 -> 8,16,32,64 ticks
    for (int c = 0; c < 4; c++) begin
      bus_write(8'(c));
      wait_expiry(8 << c, "R3");
      bus_read(8'h10, "R8");
    end
    no_pulse_for(100, "R7");                  // idle after expiry
    // restart with interval bits ignored while running
    bus_write(8'h01); idle(9); bus_write(8'h03);
    wait_expiry(16, "R5");
    bus_read(8'h10, "R4");
    // write with bit2=1 does not restart
    bus_write(8'h00); idle(3); bus_write(8'h04);
    wait_expiry(4, "R4");
    bus_read(8'h10, "R8");
    // sub-timer selection
    clk_sel = 1'b0;
    bus_write(8'h00);
    no_pulse_for(40, "R6");
    sub_tick = 1'b1;
    wait_expiry(8, "R6");
    sub_tick = 1'b0; clk_sel = 1'b1;
    bus_read(8'h10, "R6");
    // restart write on the final tick wins
    bus_write(8'h00); idle(7); bus_write(8'h00);
    chk(wdt_rst == 1'b0, "R10", "request on kick edge", wdt_rst, 0);
    wait_expiry(8, "R10");
    bus_read(8'h10, "R10");
    // external and software causes
    pulse_cause(1'b1, 1'b0); bus_read(8'h20, "R8");
    pulse_cause(1'b0, 1'b1); bus_read(8'h80, "R8");
    pulse_cause(1'b1, 1'b1); bus_read(8'hA0, "R8");
    // flags survive system reset
    pulse_cause(1'b1, 1'b0);
    rst_n = 1'b0; idle(3); rst_n = 1'b1;
    bus_read(8'h20, "R8");
    // read and cause event in the same cycle
    bus_read(8'h00, "R10", 1'b1);
    bus_read(8'h20, "R10");
    // power-up clears other flags
    pulse_cause(1'b1, 1'b1);
    por_n = 1'b0; rst_n = 1'b0; idle(2); por_n = 1'b1; rst_n = 1'b1;
    bus_read(8'h08, "R1");
    bus_read(8'h00, "R9");
    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: bench timed out");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule